// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer and Supervisor

This block is the digital controller of a display bias supply with four rails: a voltage reference, a main boost converter, a negative charge pump and a positive charge pump. It switches their enables on one at a time in that fixed order. Each rail waits until the rail before it has reported its power-up threshold. When the last rail is up, the block turns on the pull-down of an active-low open-drain ready line.

After bring-up, the block watches a below-fault flag from each rail. When a rail that has already come up drops out, two things happen. The ready pull-down is released, and every rail later in the order is switched off. The faulted rail and the rails before it stay enabled. When the faulted rail crosses its power-up threshold again, the later rails restart in order. Ready returns only when the positive rail is up again.

Pulling the active-low shutdown input low returns the block to idle with every rail off. An asserted undervoltage-lockout flag does the same. The comparators that produce the per-rail flags are outside this block, and their outputs are taken to be synchronous to `clk`.

Top module: `rail_seq`

## Requirements
- R1: During reset, and in the first cycle after it, every rail enable is low, `rdy_pull` is low and `boost_soft` is low.
- R2: If `shdn_n` is low or `uvlo` is high at a clock edge, every enable and `rdy_pull` is low after that edge, from any state.
- R3: Rail order is bit 0 reference, bit 1 main boost, bit 2 negative pump, bit 3 positive pump. From idle with `shdn_n` high and `uvlo` low, only bit 0 of `rail_en` rises, one cycle later.
- R4: `boost_soft` is high exactly while the main boost enable is high and the main rail has not yet reached its power-up threshold since it was last enabled or last faulted.
- R5: Rail i (i ≥ 1) is enabled in the cycle after a clock edge at which rail i-1 was enabled and its `up_ok` bit was high. Rails come up one per cycle at most.
- R6: `rdy_pull` goes high in the cycle after an edge at which the positive pump was enabled with `up_ok[3]` high. While it is high, all four enables are high.
- R7: If a rail that has reached its threshold has its `flt_below` bit high at an edge, three things follow after that edge. `rdy_pull` is low. Every later rail is disabled. The faulted rail and all earlier rails stay enabled.
- R8: After a fault, the later rails stay off until the faulted rail's `up_ok` bit is high at an edge. They then restart one by one in order, and `rdy_pull` returns only after the positive rail is up again.
- R9: A `flt_below` bit has no effect for a rail that has not reached its threshold since it was last enabled or last faulted.
- R10: An `up_ok` bit has no effect for a rail whose enable is low.
- R11: When several reached rails fault at the same edge, the lowest-numbered one governs. The rails after it are disabled, and it stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown request |
| uvlo | input | 1 | Input supply undervoltage-lockout flag, active high |
| up_ok | input | 4 | Per-rail power-up threshold reached |
| flt_below | input | 4 | Per-rail below-fault-threshold flag |
| rail_en | output | 4 | Per-rail enables (bit 0 reference ... bit 3 positive pump) |
| rdy_pull | output | 1 | Enables the pull-down of the active-low ready line |
| boost_soft | output | 1 | Main boost soft-start phase active |

## Verification
The hardest case to reach from the ports is a fault on a middle rail while the full supply is up, followed by recovery. One variant has a second fault at the same edge. Another has a fault flag on a rail that has not yet come up, which must be ignored. Directed sequences first bring all rails up and then drop the negative pump alone, then the main and positive rails together. Long random runs follow, biased toward threshold flags with rare faults and shutdowns, and a bench model that tracks the number of rails up checks every cycle.

// File: rtl/rail_seq.sv
module rail_seq #(
  parameter int N = 4,
  parameter int SOFT_IDX = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shdn_n,
  input  logic         uvlo,
  input  logic [N-1:0] up_ok,
  input  logic [N-1:0] flt_below,
  output logic [N-1:0] rail_en,
  output logic         rdy_pull,
  output logic         boost_soft
);

  logic [N-1:0] en_q, arm_q, en_d, arm_d, hit, kill;
  logic run;

  assign run = shdn_n & ~uvlo;
  assign hit = arm_q & flt_below;

  assign kill[0] = hit[0];
  genvar i;
  generate
    for (i = 1; i < N; i++) begin : g_kill
      assign kill[i] = kill[i-1] | hit[i];
    end
  endgenerate

  assign arm_d = {N{run}} & ~kill & (arm_q | (en_q & up_ok));

  assign en_d[0] = run;
  generate
    for (i = 1; i < N; i++) begin : g_en
      assign en_d[i] = arm_d[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      arm_q <= '0;
    end else begin
      en_q  <= en_d;
      arm_q <= arm_d;
    end
  end

  assign rail_en    = en_q;
  assign rdy_pull   = arm_q[N-1];
  assign boost_soft = en_q[SOFT_IDX] & ~arm_q[SOFT_IDX];

endmodule

// File: rtl/rail_seq_chk.sv
module rail_seq_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shdn_n,
  input logic         uvlo,
  input logic [N-1:0] up_ok,
  input logic [N-1:0] flt_below,
  input logic [N-1:0] rail_en,
  input logic         rdy_pull,
  input logic         boost_soft
);

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n || uvlo) |=> (rail_en == '0 && !rdy_pull)); // R2

  AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n && !uvlo && rail_en == '0) |=> (rail_en == N'(1))); // R3

  AST_SOFT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    boost_soft |-> (rail_en[1] && !rdy_pull)); // R4

  AST_RDY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pull |-> (&rail_en)); // R6

  AST_FAULT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pull && (|flt_below)) |=> !rdy_pull); // R7

  genvar i;
  generate
    for (i = 1; i < N; i++) begin : g_order
      AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rail_en[i] |-> rail_en[i-1]); // R5
      AST_STEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[i]) |-> $past(rail_en[i-1] && up_ok[i-1])); // R5
    end
  endgenerate

endmodule

bind rail_seq rail_seq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo),
  .up_ok(up_ok), .flt_below(flt_below), .rail_en(rail_en),
  .rdy_pull(rdy_pull), .boost_soft(boost_soft)
);

// File: tb/tb_rail_seq.sv
module tb_rail_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b0;
  logic uvlo = 1'b0;
  logic [3:0] up_ok = '0;
  logic [3:0] flt_below = '0;
  logic [3:0] rail_en;
  logic rdy_pull, boost_soft;

  int n_run = 0, n_fail = 0, ncyc = 0;
  int m_stage = 0;
  logic [3:0] m_en = '0;
  bit done = 0;

  always #5 clk = ~clk;

  rail_seq dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo),
    .up_ok(up_ok), .flt_below(flt_below), .rail_en(rail_en),
    .rdy_pull(rdy_pull), .boost_soft(boost_soft)
  );

  function automatic int next_stage(int s, logic [3:0] me, logic run,
                                    logic [3:0] up, logic [3:0] fl);
    if (!run) return 0;
    for (int j = 0; j < s; j++) if (fl[j]) return j;
    if (s < 4 && me[s] && up[s]) return s + 1;
    return s;
  endfunction

  task automatic check(string tag);
    logic exp_rdy, exp_soft;
    exp_rdy  = (m_stage == 4);
    exp_soft = m_en[1] && (m_stage < 2);
    n_run++;
    if (rail_en !== m_en || rdy_pull !== exp_rdy || boost_soft !== exp_soft) begin
      n_fail++;
      $display("FAIL %s: en=%b rdy=%b soft=%b expected en=%b rdy=%b soft=%b",
               tag, rail_en, rdy_pull, boost_soft, m_en, exp_rdy, exp_soft);
    end
  endtask

  task automatic step(string tag);
    int ns;
    logic run;
    run = shdn_n && !uvlo;
    ns = next_stage(m_stage, m_en, run, up_ok, flt_below);
    @(posedge clk);
    #1;
    m_stage = ns;
    for (int i = 0; i < 4; i++) m_en[i] = run && (i <= ns);
    @(negedge clk);
    ncyc++;
    check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step("R1");
    shdn_n = 1'b1;
    flt_below = 4'b1111;
    up_ok = 4'b1100;
    step("R3");
    step("R9");
    step("R10");
    flt_below = '0;
    up_ok = 4'b0001;
    step("R4");
    step("R4");
    up_ok = 4'b0011;
    step("R5");
    up_ok = 4'b0111;
    step("R5");
    up_ok = 4'b1111;
    step("R6");
    step("R6");
    up_ok = 4'b1011;
    flt_below = 4'b0100;
    step("R7");
    step("R7");
    step("R7");
    flt_below = '0;
    step("R8");
    up_ok = 4'b1111;
    step("R8");
    step("R8");
    step("R8");
    step("R8");
    flt_below = 4'b1010;
    up_ok = 4'b0101;
    step("R11");
    step("R11");
    flt_below = '0;
    up_ok = 4'b1111;
    repeat (4) step("R8");
    uvlo = 1'b1;
    step("R2");
    step("R2");
    uvlo = 1'b0;
    repeat (5) step("R3");
    shdn_n = 1'b0;
    step("R2");
    shdn_n = 1'b1;
    void'($urandom(32'h1ce5));
    for (int k = 0; k < 4000; k++) begin
      shdn_n    = ($urandom_range(0, 99) != 0);
      uvlo      = ($urandom_range(0, 199) == 0);
      up_ok     = 4'($urandom) | 4'($urandom);
      flt_below = ($urandom_range(0, 19) == 0) ? 4'($urandom) : 4'b0000;
      step("R8");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule